// File: doc/BRIEF.md
# Local-History Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It works in two levels. A first-level table of per-branch history shift registers is selected by a slice of the branch address. The pattern held in the selected entry then addresses a second-level table of 2-bit saturating counters, and the counter's upper bit is the prediction. Because the counter is chosen by the branch's own recent outcome sequence rather than by its address, a branch with a repeating taken/not-taken rhythm trains a separate counter for each point in that rhythm, and the block learns it.

The fetch stage drives a branch address on the lookup port and reads the prediction in the same cycle. When the branch resolves, the execute stage drives the branch address and its real direction on the update port. On that clock edge the selected counter moves one step toward the outcome, and the outcome is shifted into that branch's history entry. Both table depths are set by parameters: the history table has `2**BHT_IDX_W` entries and the counter table has `2**HIST_W` counters.

Top module: `lhist_bpred`

## Requirements
- R1: The history entry for an address is chosen by `pc[IDX_LSB +: BHT_IDX_W]`. Address bits outside that slice have no effect, so two addresses that agree in the slice share one entry.
- R2: `lk_taken` depends only on the current table state and `lk_pc`, within the same cycle. It equals bit 1 of the counter addressed by the history pattern of `lk_pc`'s entry, and 1 means taken.
- R3: On an update, the selected counter increments when `upd_taken` is 1 and decrements when it is 0.
- R4: A counter stays at 3 on a further taken outcome and stays at 0 on a further not-taken outcome.
- R5: On an update, the addressed history entry shifts left by one bit. `upd_taken` enters bit 0 (1 = taken) and the oldest bit is dropped.
- R6: The counter written by an update is the one addressed by the history value from before that same update's shift.
- R7: After synchronous active-low reset, every history entry is 0 and every counter is 1 (weakly not-taken), so every address predicts not-taken.
- R8: A lookup in the same cycle as an update sees the tables as they were before that update. The update's effect shows from the next cycle on.
- R9: A counter at 3 needs two consecutive not-taken outcomes before it predicts not-taken, and a counter at 0 needs two taken outcomes before it predicts taken. A single unusual outcome does not flip a saturated counter.
- R10: While `upd_valid` is 0, neither table changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_taken | output | 1 | Prediction for `lk_pc`, 1 = taken |
| upd_valid | input | 1 | Resolved branch present this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction, 1 = taken |

## Verification
The bench builds the block with a 4-bit history (16 counters), an 8-entry history table and an index starting at bit 2. With these sizes, counter saturation, full history wrap and every history pattern are reached within a few dozen updates. Two addresses that differ only above bit 4 collide in one entry, so aliasing can be checked directly. A long random stream of lookups and updates, with few distinct addresses, repeatedly drives a lookup and an update at the same entry in the same cycle and makes different branches share counters through equal histories.

// File: rtl/lhb_pkg.sv
// Shared types and the counter step function for the local-history predictor.
// Assumes 2-bit counters; the prediction is the counter's upper bit.
package lhb_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_MAX  = 2'd3;
    localparam ctr2_t CTR_MIN  = 2'd0;
    localparam ctr2_t CTR_INIT = 2'd1;   // weakly not-taken

    // Move a counter one step toward the outcome, holding at the ends.
    function automatic ctr2_t ctr_step(input ctr2_t cur, input logic taken);
        ctr2_t res;
        if (taken) res = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
        else       res = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
        return res;
    endfunction

endpackage

// File: rtl/lhb_pc_slice.sv
// Picks the history-table index out of a branch address.
// Assumes IDX_LSB + IDX_W <= PC_W; every other address bit is ignored.
module lhb_pc_slice #(
    parameter int PC_W    = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 8
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);

    // Extract the index bits; the variant depends on alignment.
    generate
        if (IDX_LSB == 0) begin : g_no_skip
            assign idx = pc[IDX_W-1:0];
        end else begin : g_skip
            assign idx = pc[IDX_LSB +: IDX_W];
        end
    endgenerate

    // Bits outside the slice have no function here by design.
    logic unused_pc_bits;
    assign unused_pc_bits = ^pc;

endmodule

// File: rtl/lhb_hist_table.sv
// First-level table: one history shift register per index.
// A read port serves lookups. An update port reads the current pattern
// and, when enabled, shifts the outcome into bit 0 at the clock edge.
// Assumes HIST_W >= 2. The reset is synchronous and active low.
module lhb_hist_table #(
    parameter int IDX_W  = 8,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              up_en,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic              up_taken,
    output logic [HIST_W-1:0] up_hist
);

    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist_q [DEPTH];
    logic [HIST_W-1:0] hist_shifted;

    // Read both ports from the current state.
    assign rd_hist = hist_q[rd_idx];
    assign up_hist = hist_q[up_idx];

    // Oldest bit falls off the top; the new outcome enters bit 0.
    assign hist_shifted = (up_hist << 1) | HIST_W'(up_taken);

    // Clear on reset, otherwise write the shifted pattern back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) hist_q[e] <= '0;
        end else if (up_en) begin
            hist_q[up_idx] <= hist_shifted;
        end
    end

endmodule

// File: rtl/lhb_ctr_table.sv
// Second-level table: 2**PAT_W saturating counters addressed by a history
// pattern. A read port serves lookups; the update port steps one counter.
// The reset is synchronous and active low; counters start weakly not-taken.
module lhb_ctr_table
    import lhb_pkg::*;
#(
    parameter int PAT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PAT_W-1:0] rd_pat,
    output ctr2_t            rd_ctr,
    input  logic             up_en,
    input  logic [PAT_W-1:0] up_pat,
    input  logic             up_taken,
    output ctr2_t            up_ctr,
    output ctr2_t            up_ctr_nxt
);

    localparam int DEPTH = 1 << PAT_W;

    ctr2_t ctr_q [DEPTH];

    // Read both ports from the current state.
    assign rd_ctr     = ctr_q[rd_pat];
    assign up_ctr     = ctr_q[up_pat];
    assign up_ctr_nxt = ctr_step(up_ctr, up_taken);

    // Set to the initial value on reset, otherwise write the stepped counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) ctr_q[e] <= CTR_INIT;
        end else if (up_en) begin
            ctr_q[up_pat] <= up_ctr_nxt;
        end
    end

endmodule

// File: rtl/lhist_bpred.sv
// Local-history two-level branch direction predictor.
// Lookup is combinational from lk_pc. An update steps the counter selected
// by the pre-shift history, then shifts the outcome into that history.
// Assumes HIST_W >= 2 and IDX_LSB + BHT_IDX_W <= PC_W.
module lhist_bpred
    import lhb_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int IDX_LSB   = 2,
    parameter int BHT_IDX_W = 8,
    parameter int HIST_W    = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    logic [BHT_IDX_W-1:0] lk_idx;
    logic [BHT_IDX_W-1:0] upd_idx;
    logic [HIST_W-1:0]    lk_hist;
    logic [HIST_W-1:0]    upd_hist;
    ctr2_t                lk_ctr;
    ctr2_t                upd_ctr;
    ctr2_t                upd_ctr_nxt;

    // Index for the lookup address.
    lhb_pc_slice #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(BHT_IDX_W)) u_lk_slice (
        .pc  (lk_pc),
        .idx (lk_idx)
    );

    // Index for the update address.
    lhb_pc_slice #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(BHT_IDX_W)) u_up_slice (
        .pc  (upd_pc),
        .idx (upd_idx)
    );

    // Per-branch outcome histories.
    lhb_hist_table #(.IDX_W(BHT_IDX_W), .HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_hist  (lk_hist),
        .up_en    (upd_valid),
        .up_idx   (upd_idx),
        .up_taken (upd_taken),
        .up_hist  (upd_hist)
    );

    // Pattern-addressed counters; the update uses the pre-shift history.
    lhb_ctr_table #(.PAT_W(HIST_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_pat     (lk_hist),
        .rd_ctr     (lk_ctr),
        .up_en      (upd_valid),
        .up_pat     (upd_hist),
        .up_taken   (upd_taken),
        .up_ctr     (upd_ctr),
        .up_ctr_nxt (upd_ctr_nxt)
    );

    // The prediction is the counter's upper bit.
    assign lk_taken = lk_ctr[1];

endmodule

// File: rtl/lhist_bpred_chk.sv
// Property checker for lhist_bpred, attached with bind below.
// Observes the update path and the lookup output over time.
module lhist_bpred_chk #(
    parameter int BHT_IDX_W = 8,
    parameter int HIST_W    = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lk_taken,
    input logic                 upd_valid,
    input logic                 upd_taken,
    input logic [BHT_IDX_W-1:0] upd_idx,
    input logic [HIST_W-1:0]    upd_hist,
    input logic [1:0]           upd_ctr,
    input logic [1:0]           upd_ctr_nxt
);

    AST_RESET_PREDICT_NT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_taken);                                      // R7

    AST_RESET_TABLE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && upd_valid) |-> (upd_hist == '0 && upd_ctr == 2'd1)); // R7

    AST_CTR_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_ctr != 2'd3) |-> upd_ctr_nxt == upd_ctr + 2'd1); // R3

    AST_CTR_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && upd_ctr != 2'd0) |-> upd_ctr_nxt == upd_ctr - 2'd1); // R3

    AST_CTR_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_ctr == 2'd3) |-> upd_ctr_nxt == 2'd3); // R4

    AST_CTR_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && upd_ctr == 2'd0) |-> upd_ctr_nxt == 2'd0); // R4

    AST_HIST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && $past(upd_valid) && upd_idx == $past(upd_idx))
        |-> upd_hist == {$past(upd_hist[HIST_W-2:0]), $past(upd_taken)}); // R5

    AST_CTR_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && $past(upd_valid) && upd_hist == $past(upd_hist))
        |-> upd_ctr == $past(upd_ctr_nxt));                                // R6

endmodule

bind lhist_bpred lhist_bpred_chk #(.BHT_IDX_W(BHT_IDX_W), .HIST_W(HIST_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_taken    (lk_taken),
    .upd_valid   (upd_valid),
    .upd_taken   (upd_taken),
    .upd_idx     (upd_idx),
    .upd_hist    (upd_hist),
    .upd_ctr     (upd_ctr),
    .upd_ctr_nxt (upd_ctr_nxt)
);

// File: tb/lhist_bpred_tb_top.sv
// Bench: behavioural table model updated on every clock and compared with
// the prediction each cycle.
module lhist_bpred_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 32;
    localparam int IDX_LSB    = 2;
    localparam int BHT_IDX_W  = 3;
    localparam int HIST_W     = 4;
    localparam int N_ENT      = 1 << BHT_IDX_W;
    localparam int N_CTR      = 1 << HIST_W;
    localparam int HMASK      = N_CTR - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int hist_m [N_ENT];
    int ctr_m  [N_CTR];
    bit done = 0;

    lhist_bpred #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .BHT_IDX_W(BHT_IDX_W), .HIST_W(HIST_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (lk_pc),
        .lk_taken  (lk_taken),
        .upd_valid (upd_valid),
        .upd_pc    (upd_pc),
        .upd_taken (upd_taken)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ent_of(input logic [PC_W-1:0] pc);
        return int'((pc >> IDX_LSB) & (N_ENT - 1));
    endfunction

    function automatic bit model_pred(input logic [PC_W-1:0] pc);
        return ctr_m[hist_m[ent_of(pc)]] >= 2;
    endfunction

    task automatic model_reset();
        for (int e = 0; e < N_ENT; e++) hist_m[e] = 0;
        for (int c = 0; c < N_CTR; c++) ctr_m[c] = 1;
    endtask

    task automatic check(input string tag, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: lk_taken=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model
    // to the state the next rising edge produces.
    task automatic step(input string tag, input logic [PC_W-1:0] lpc,
                        input bit uv, input logic [PC_W-1:0] upc, input bit ut);
        @(negedge clk);
        lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        #1;
        check(tag, lk_taken, model_pred(lpc));   // R8: pre-update view
        if (uv) begin
            int e = ent_of(upc);
            int p = hist_m[e];                     // R6: pre-shift pattern
            if (ut) ctr_m[p] = (ctr_m[p] == 3) ? 3 : ctr_m[p] + 1;
            else    ctr_m[p] = (ctr_m[p] == 0) ? 0 : ctr_m[p] - 1;
            hist_m[e] = ((p << 1) | int'(ut)) & HMASK;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [PC_W-1:0] pa = 32'h0000_1004;
        logic [PC_W-1:0] pb = 32'h0000_1008;
        logic [PC_W-1:0] pc_alias = 32'hABCD_1004;  // same slice as pa
        logic [31:0]     lfsr = 32'hACE1_2468;
        model_reset();
        repeat (3) @(negedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R7: reset state, every entry predicts not-taken (explicit 0).
        for (int i = 0; i < N_ENT; i++) begin
            @(negedge clk); lk_pc = PC_W'(i << IDX_LSB); #1;
            check("R7", lk_taken, 1'b0);
        end

        // R3/R4: an always-taken branch drives counters up and holds at 3.
        for (int i = 0; i < 12; i++) step("R4", pa, 1'b1, pa, 1'b1);
        check("R3", lk_taken, 1'b1);

        // R9: one not-taken on a saturated pattern, then taken again.
        step("R9", pa, 1'b1, pa, 1'b0);
        for (int i = 0; i < 6; i++) step("R9", pa, 1'b1, pa, 1'b1);

        // R5/R2: an alternating branch is learned through its history.
        for (int i = 0; i < 24; i++) step("R5", pb, 1'b1, pb, i[0]);

        // R10: no update, predictions unchanged over many cycles.
        for (int i = 0; i < 8; i++) step("R10", (i[0] ? pa : pb), 1'b0, pb, 1'b1);

        // R1: an address differing only above the slice uses pa's entry.
        step("R1", pc_alias, 1'b1, pc_alias, 1'b0);
        step("R1", pa, 1'b1, pc_alias, 1'b0);
        step("R1", pa, 1'b0, pa, 1'b0);

        // R8: lookup and update of the same address in the same cycle.
        for (int i = 0; i < 10; i++) step("R8", pa, 1'b1, pa, i[1]);

        // R2/R6: random mix over a few addresses.
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step("R2", {lfsr[31:20], 15'd0, lfsr[4:0]}, lfsr[10],
                 {lfsr[19:8], 15'd0, lfsr[14:12], 2'b00}, lfsr[6] | lfsr[7]);
        end

        // R7: a second reset restores the weak not-taken state.
        @(negedge clk); rst_n = 1'b0; upd_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1; model_reset();
        for (int i = 0; i < N_ENT; i++) step("R7", PC_W'(i << IDX_LSB), 1'b0, '0, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule